// File: doc/BRIEF.md
# Multihit Channel Hit Recorder with Threshold Readout

This block records hit times for a group of time-digitizer channels. A free-running coarse time counter is sampled whenever a channel input shows the selected edge, and the sample is pushed into that channel's own last-in-first-out store. The usable store depth is set by configuration. This puts an upper bound on how long readout of one channel can take. A hit that arrives while the store is full is not stored, but it still advances the channel's hit count.

A common reference hit stops acquisition. In common-stop operation readout begins at once. In common-start operation the reference hit clears the stores and opens recording, and a separate timeout edge then starts readout. The readout sequencer visits the channels in ascending order. It pops each stored time, newest first, and forms the difference against the reference time. A value is kept only if it is not above a full-scale limit set in steps of 16 counts and is strictly above that channel's own sparse constant. Kept values leave as 32-bit words on a valid/ready stream. Channels with nothing stored produce no words. Once readout ends, every channel is empty and its hit count is back to zero.

Top module: `mhit_tdc_group`

## Requirements
- R1: Within one channel, stored times are read out newest first, and at most one store is popped per cycle.
- R2: The effective depth is cfg_depth, with 0 treated as 1 and values above 16 treated as 16. Hits arriving at a full store are not stored.
- R3: cfg_edge selects the recorded edges: 2'b01 rising only, 2'b10 falling only, 2'b11 both, 2'b00 none.
- R4: When cfg_stop_mode=1 the value is the common capture time minus the hit capture time. When cfg_stop_mode=0 it is the hit time minus the common time. Both are in clock cycles, modulo 2^16.
- R5: A value greater than (cfg_fullscale+1)*16 is discarded. A value equal to that limit is kept.
- R6: A value is kept only if it is strictly greater than the channel's constant cfg_sparse[16*ch+15:16*ch].
- R7: Bits [17:16] of each word hold the number of selected edges seen by the channel during recording, modulo 4, including the hits that were not stored.
- R8: The word layout is [31:27] module address, [26:20] channel, [19:18] zero, [17:16] hit count, [15:0] value. Channels come out in ascending order, and a channel with no stored hits emits nothing.
- R9: In common-start operation, edges before the common hit are ignored, the common hit clears all stores and opens recording, and a rising timeout_in starts readout.
- R10: out_valid with out_data is held unchanged until out_ready. busy is high during readout, and edges seen while busy are not recorded. After readout all stores and counts are empty. After reset out_valid and busy are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_in | input | NCH | Channel hit inputs, one bit per channel |
| common_in | input | 1 | Common reference hit, active on its rising edge |
| timeout_in | input | 1 | Rising edge starts readout in common-start operation |
| cfg_edge | input | 2 | Edge selection (R3) |
| cfg_depth | input | $clog2(DEPTH+1) | Store depth limit (R2) |
| cfg_stop_mode | input | 1 | 1 = common stop, 0 = common start |
| cfg_fullscale | input | 12 | Full-scale code; limit is (code+1)*16 |
| cfg_sparse | input | NCH*16 | Per-channel lower constants |
| cfg_module_addr | input | 5 | Module address placed in every word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 32 | Formatted data word |
| busy | output | 1 | Readout in progress |

## Verification
The hardest states to reach from the ports are the ones that depend on exact timing. Examples are a value landing exactly on the 16-count full-scale limit or exactly on a sparse constant, and channel edges arriving while a stalled readout holds the stream. The directed tasks place each edge a known number of cycles before the common hit, so they produce values of 16, 17, 20 and 21 on purpose. One task throttles out_ready with a pseudo-random pattern and pulses a channel during readout, then runs an empty event to show that nothing leaked through.

// File: rtl/mhit_pkg.sv
package mhit_pkg;

  localparam int TW     = 16;
  localparam int WORD_W = 32;
  localparam int FS_W   = 12;

  typedef enum logic [1:0] {
    SEQ_ACQ   = 2'd0,
    SEQ_ARMED = 2'd1,
    SEQ_RUN   = 2'd2
  } seq_state_e;

  // Signed sense of the measurement is chosen by the mode bit.
  function automatic logic [TW-1:0] span_of(input logic [TW-1:0] hit_t,
                                            input logic [TW-1:0] ref_t,
                                            input logic          stop_mode);
    return stop_mode ? (ref_t - hit_t) : (hit_t - ref_t);
  endfunction

  // Upper acceptance limit in counts: (code+1) steps of 16.
  function automatic logic [TW:0] fs_limit(input logic [FS_W-1:0] code);
    logic [TW:0] steps;
    steps = {{(TW+1-FS_W){1'b0}}, code} + 1'b1;
    return steps << 4;
  endfunction

  function automatic logic keep_value(input logic [TW-1:0]   val,
                                      input logic [FS_W-1:0] code,
                                      input logic [TW-1:0]   floor_v);
    return ({1'b0, val} <= fs_limit(code)) && (val > floor_v);
  endfunction

  function automatic logic [WORD_W-1:0] make_word(input logic [4:0]    addr,
                                                  input logic [6:0]    chan,
                                                  input logic [1:0]    hcount,
                                                  input logic [TW-1:0] val);
    return {addr, chan, 2'b00, hcount, val};
  endfunction

endpackage

// File: rtl/mhit_edge_sel.sv
module mhit_edge_sel #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] sig_in,
  input  logic [1:0]     edge_mode,
  output logic [NCH-1:0] hit
);

  logic [NCH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig_in;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic rise_w, fall_w;
    assign rise_w = sig_in[g] & ~prev_q[g];
    assign fall_w = ~sig_in[g] & prev_q[g];
    assign hit[g] = (edge_mode[0] & rise_w) | (edge_mode[1] & fall_w);

    // R3: a rising event never reports when only falling edges are chosen
    p_edge_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode == 2'b10 && hit[g]) |-> (prev_q[g] && !sig_in[g]));
  end

endmodule

// File: rtl/mhit_lifo.sv
module mhit_lifo #(
  parameter int DEPTH = 16,
  parameter int TW    = 16,
  parameter int CW    = $clog2(DEPTH+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [TW-1:0] stamp,
  input  logic          pop,
  input  logic          clear,
  input  logic [CW-1:0] depth_lim,
  output logic [TW-1:0] top,
  output logic [CW-1:0] count,
  output logic [1:0]    hits
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [TW-1:0] mem [DEPTH];
  logic          store_full;
  logic          store_write;
  logic          store_read;

  assign store_full  = (count >= depth_lim);
  assign store_write = push && !clear && !store_full;
  assign store_read  = pop && !clear && (count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      hits  <= '0;
    end else if (clear) begin
      count <= '0;
      hits  <= '0;
    end else begin
      if (store_read)       count <= count - 1'b1;
      else if (store_write) count <= count + 1'b1;
      if (push)             hits  <= hits + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (store_write) mem[AW'(count)] <= stamp;
  end

  assign top = (count != '0) ? mem[AW'(count - 1'b1)] : '0;

  // R2: a push into a full store leaves the occupancy untouched
  p_full_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clear && !pop && count >= depth_lim) |=> (count == $past(count)));

  // R2: occupancy never exceeds the physical depth
  p_depth_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R1: the sequencer only pops a store that holds data
  p_pop_nonempty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));

endmodule

// File: rtl/mhit_readout_seq.sv
module mhit_readout_seq
  import mhit_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 common_rise,
  input  logic                 timeout_rise,
  input  logic                 stop_mode,
  input  logic [TW-1:0]        tcount,
  input  logic [NCH*CW-1:0]    counts,
  input  logic [NCH*2-1:0]     hitcnts,
  input  logic [NCH*TW-1:0]    tops,
  input  logic [FS_W-1:0]      cfg_fullscale,
  input  logic [NCH*TW-1:0]    cfg_sparse,
  input  logic [4:0]           cfg_module_addr,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic [WORD_W-1:0]    out_data,
  output logic [NCH-1:0]       pop_vec,
  output logic [NCH-1:0]       clr_vec,
  output logic                 clr_all,
  output logic                 rec_en,
  output logic                 busy
);

  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  seq_state_e     state;
  logic [CHW-1:0] ch_idx;
  logic [TW-1:0]  common_q;

  logic [CW-1:0]  cur_cnt;
  logic [1:0]     cur_hits;
  logic [TW-1:0]  cur_top;
  logic [TW-1:0]  cur_floor;
  logic [TW-1:0]  cur_diff;
  logic           cur_keep;
  logic           chan_done;
  logic           last_chan;

  assign cur_cnt   = counts[ch_idx*CW +: CW];
  assign cur_hits  = hitcnts[ch_idx*2 +: 2];
  assign cur_top   = tops[ch_idx*TW +: TW];
  assign cur_floor = cfg_sparse[ch_idx*TW +: TW];
  assign cur_diff  = span_of(cur_top, common_q, stop_mode);
  assign cur_keep  = keep_value(cur_diff, cfg_fullscale, cur_floor);
  assign chan_done = (state == SEQ_RUN) && (cur_cnt == '0);
  assign last_chan = (ch_idx == CHW'(NCH-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SEQ_ACQ;
      ch_idx   <= '0;
      common_q <= '0;
    end else begin
      unique case (state)
        SEQ_ACQ: begin
          if (common_rise) begin
            common_q <= tcount;
            ch_idx   <= '0;
            state    <= stop_mode ? SEQ_RUN : SEQ_ARMED;
          end
        end
        SEQ_ARMED: begin
          if (timeout_rise) begin
            ch_idx <= '0;
            state  <= SEQ_RUN;
          end
        end
        SEQ_RUN: begin
          if (chan_done) begin
            if (last_chan) state  <= SEQ_ACQ;
            else           ch_idx <= ch_idx + 1'b1;
          end
        end
        default: state <= SEQ_ACQ;
      endcase
    end
  end

  assign out_valid = (state == SEQ_RUN) && (cur_cnt != '0) && cur_keep;
  assign out_data  = make_word(cfg_module_addr, 7'(ch_idx), cur_hits, cur_diff);
  assign busy      = (state == SEQ_RUN);
  assign rec_en    = ((state == SEQ_ACQ) && stop_mode) || (state == SEQ_ARMED);
  assign clr_all   = (state == SEQ_ACQ) && common_rise && !stop_mode;

  always_comb begin
    pop_vec = '0;
    clr_vec = '0;
    if (state == SEQ_RUN) begin
      if (cur_cnt == '0)                 clr_vec[ch_idx] = 1'b1;
      else if (!cur_keep || out_ready)   pop_vec[ch_idx] = 1'b1;
    end
  end

  // R10: a stalled word stays put until it is accepted
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R5: nothing above the full-scale limit reaches the stream
  p_cut_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ({1'b0, out_data[TW-1:0]} <= fs_limit(cfg_fullscale)));

  // R6: every emitted value clears its channel's constant
  p_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[TW-1:0] > cur_floor));

  // R8: channel scan never steps backwards during one readout
  p_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_RUN) |=> (state != SEQ_RUN || ch_idx >= $past(ch_idx)));

endmodule

// File: rtl/mhit_tdc_group.sv
module mhit_tdc_group
  import mhit_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int DEPTH = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NCH-1:0]              chan_in,
  input  logic                        common_in,
  input  logic                        timeout_in,
  input  logic [1:0]                  cfg_edge,
  input  logic [$clog2(DEPTH+1)-1:0]  cfg_depth,
  input  logic                        cfg_stop_mode,
  input  logic [11:0]                 cfg_fullscale,
  input  logic [NCH*16-1:0]           cfg_sparse,
  input  logic [4:0]                  cfg_module_addr,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [31:0]                 out_data,
  output logic                        busy
);

  localparam int CW = $clog2(DEPTH+1);

  logic [TW-1:0]     tcount;
  logic              common_prev, timeout_prev;
  logic              common_rise, timeout_rise;
  logic [NCH-1:0]    hit_vec;
  logic [NCH-1:0]    push_vec;
  logic [NCH-1:0]    pop_vec;
  logic [NCH-1:0]    clr_vec;
  logic              clr_all;
  logic              rec_en;
  logic [CW-1:0]     depth_lim;
  logic [NCH*CW-1:0] counts;
  logic [NCH*2-1:0]  hitcnts;
  logic [NCH*TW-1:0] tops;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcount       <= '0;
      common_prev  <= 1'b0;
      timeout_prev <= 1'b0;
    end else begin
      tcount       <= tcount + 1'b1;
      common_prev  <= common_in;
      timeout_prev <= timeout_in;
    end
  end

  assign common_rise  = common_in & ~common_prev;
  assign timeout_rise = timeout_in & ~timeout_prev;

  always_comb begin
    if (cfg_depth == '0)                depth_lim = CW'(1);
    else if (cfg_depth > CW'(DEPTH))    depth_lim = CW'(DEPTH);
    else                                depth_lim = cfg_depth;
  end

  mhit_edge_sel #(.NCH(NCH)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .sig_in    (chan_in),
    .edge_mode (cfg_edge),
    .hit       (hit_vec)
  );

  assign push_vec = rec_en ? hit_vec : '0;

  for (genvar g = 0; g < NCH; g++) begin : g_store
    mhit_lifo #(.DEPTH(DEPTH), .TW(TW), .CW(CW)) u_lifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push_vec[g]),
      .stamp     (tcount),
      .pop       (pop_vec[g]),
      .clear     (clr_vec[g] | clr_all),
      .depth_lim (depth_lim),
      .top       (tops[g*TW +: TW]),
      .count     (counts[g*CW +: CW]),
      .hits      (hitcnts[g*2 +: 2])
    );
  end

  mhit_readout_seq #(.NCH(NCH), .CW(CW)) u_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .common_rise     (common_rise),
    .timeout_rise    (timeout_rise),
    .stop_mode       (cfg_stop_mode),
    .tcount          (tcount),
    .counts          (counts),
    .hitcnts         (hitcnts),
    .tops            (tops),
    .cfg_fullscale   (cfg_fullscale),
    .cfg_sparse      (cfg_sparse),
    .cfg_module_addr (cfg_module_addr),
    .out_ready       (out_ready),
    .out_valid       (out_valid),
    .out_data        (out_data),
    .pop_vec         (pop_vec),
    .clr_vec         (clr_vec),
    .clr_all         (clr_all),
    .rec_en          (rec_en),
    .busy            (busy)
  );

  // R10: no store is written while readout runs
  p_quiet_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (push_vec == '0));

  // R1: at most one store is popped per cycle
  p_single_pop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pop_vec));

  // R10: stream is idle whenever readout is not running
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid);

endmodule

// File: tb/test_mhit_tdc_group.sv
module test_mhit_tdc_group;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int DEPTH = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NCH-1:0]  chan_in = '0;
  logic            common_in = 1'b0;
  logic            timeout_in = 1'b0;
  logic [1:0]      cfg_edge = 2'b01;
  logic [4:0]      cfg_depth = 5'd16;
  logic            cfg_stop_mode = 1'b1;
  logic [11:0]     cfg_fullscale = 12'hFFF;
  logic [NCH*16-1:0] cfg_sparse = '0;
  logic [4:0]      cfg_module_addr = 5'h13;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [31:0]     out_data;
  logic            busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  mhit_tdc_group #(.NCH(NCH), .DEPTH(DEPTH)) i_mhit_tdc_group (
    .clk(clk), .rst_n(rst_n), .chan_in(chan_in), .common_in(common_in),
    .timeout_in(timeout_in), .cfg_edge(cfg_edge), .cfg_depth(cfg_depth),
    .cfg_stop_mode(cfg_stop_mode), .cfg_fullscale(cfg_fullscale),
    .cfg_sparse(cfg_sparse), .cfg_module_addr(cfg_module_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .busy(busy)
  );

  int n_checks = 0;
  int n_fail = 0;
  int now = 0;
  bit bp_mode = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  int  m_time [NCH][DEPTH];
  int  m_n [NCH];
  int  m_hits [NCH];
  bit  m_rec = 1'b1;
  int  m_com = 0;

  logic [31:0] cap [256];
  int ncap = 0;
  logic [31:0] expw [256];
  int nexp = 0;
  bit stall_prev = 1'b0;
  logic [31:0] prev_data = '0;

  always @(posedge clk) if (rst_n) now <= now + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  // Stream monitor: throttles ready, records accepted words, checks stall hold (R10)
  always @(negedge clk) begin
    out_ready = bp_mode ? lfsr[0] : 1'b1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    #1;
    if (stall_prev) chk(out_valid && out_data == prev_data, "R10 hold", out_data, prev_data);
    stall_prev = out_valid && !out_ready;
    prev_data = out_data;
    if (out_valid && out_ready && ncap < 256) begin
      cap[ncap] = out_data;
      ncap++;
    end
  end

  function automatic int deff();
    if (cfg_depth == 0) return 1;
    if (cfg_depth > DEPTH) return DEPTH;
    return int'(cfg_depth);
  endfunction

  task automatic drive(input logic [NCH-1:0] v);
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      logic r, f;
      r = v[c] && !chan_in[c];
      f = !v[c] && chan_in[c];
      if (m_rec && ((r && cfg_edge[0]) || (f && cfg_edge[1]))) begin
        m_hits[c]++;
        if (m_n[c] < deff()) begin
          m_time[c][m_n[c]] = now;
          m_n[c]++;
        end
      end
    end
    chan_in = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(chan_in);
  endtask

  task automatic pulse(input int c);
    drive(chan_in | (8'h1 << c));
    drive(chan_in & ~(8'h1 << c));
  endtask

  task automatic clear_model();
    for (int c = 0; c < NCH; c++) begin
      m_n[c] = 0;
      m_hits[c] = 0;
    end
  endtask

  task automatic begin_event();
    ncap = 0;
    clear_model();
    m_rec = cfg_stop_mode;
  endtask

  task automatic common_pulse();
    @(negedge clk);
    common_in = 1'b1;
    m_com = now;
    if (cfg_stop_mode) m_rec = 1'b0;
    else begin
      clear_model();
      m_rec = 1'b1;
    end
    @(negedge clk);
    common_in = 1'b0;
  endtask

  task automatic timeout_pulse();
    @(negedge clk);
    timeout_in = 1'b1;
    m_rec = 1'b0;
    @(negedge clk);
    timeout_in = 1'b0;
  endtask

  task automatic finish_event(input string tag);
    int guard;
    nexp = 0;
    for (int c = 0; c < NCH; c++) begin
      for (int i = m_n[c] - 1; i >= 0; i--) begin
        int d, lim, fl;
        d = cfg_stop_mode ? (m_com - m_time[c][i]) : (m_time[c][i] - m_com);
        d = d & 16'hFFFF;
        lim = (int'(cfg_fullscale) + 1) * 16;
        fl = int'(cfg_sparse[c*16 +: 16]);
        if (d <= lim && d > fl) begin
          expw[nexp] = {cfg_module_addr, 7'(c), 2'b00, 2'(m_hits[c]), 16'(d)};
          nexp++;
        end
      end
    end
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (busy && guard < 5000);
    #2;
    chk(!busy, {tag, " readout end"}, 32'(busy), 32'd0);
    chk(ncap == nexp, {tag, " word count"}, 32'(ncap), 32'(nexp));
    for (int i = 0; i < ncap && i < nexp; i++)
      chk(cap[i] == expw[i], {tag, " word"}, cap[i], expw[i]);
    clear_model();
    m_rec = cfg_stop_mode;
  endtask

  task automatic t_reset();
    chk(!out_valid && !busy, "R10 reset state", {30'd0, out_valid, busy}, 32'd0);
  endtask

  task automatic t_basic_stop();
    begin_event();
    pulse(0); idle(3); pulse(2); pulse(0); idle(5);
    drive(8'b0001_0010); drive(8'h00);
    pulse(5); pulse(0); pulse(5); idle(2);
    common_pulse();
    finish_event("R1 R4 R8 stop order");
  endtask

  task automatic t_edges();
    cfg_edge = 2'b10;
    begin_event();
    pulse(1); idle(2); pulse(1); idle(1);
    common_pulse();
    finish_event("R3 falling");
    cfg_edge = 2'b11;
    begin_event();
    drive(8'h08); idle(3); drive(8'h00); idle(1); pulse(6); idle(1);
    common_pulse();
    finish_event("R3 both");
    cfg_edge = 2'b00;
    begin_event();
    pulse(1); pulse(4); idle(1);
    common_pulse();
    finish_event("R3 none");
    cfg_edge = 2'b01;
  endtask

  task automatic t_depth();
    cfg_depth = 5'd2;
    begin_event();
    for (int i = 0; i < 5; i++) pulse(3);
    idle(1); common_pulse();
    finish_event("R2 R7 depth2");
    cfg_depth = 5'd0;
    begin_event();
    for (int i = 0; i < 3; i++) pulse(6);
    idle(1); common_pulse();
    finish_event("R2 R7 depth0");
    cfg_depth = 5'd16;
    begin_event();
    for (int i = 0; i < 4; i++) pulse(2);
    idle(1); common_pulse();
    finish_event("R7 wrap");
    cfg_depth = 5'd20;
    begin_event();
    for (int i = 0; i < 17; i++) pulse(7);
    idle(1); common_pulse();
    finish_event("R2 above max");
    cfg_depth = 5'd16;
  endtask

  task automatic t_fullscale();
    // values 40 and 17 on ch0, 16 on ch1, 10 on ch2 against a limit of 16
    cfg_fullscale = 12'd0;
    begin_event();
    drive(8'h01); drive(8'h00); idle(21);
    drive(8'h01); drive(8'h03); drive(8'h00); idle(4);
    drive(8'h04); drive(8'h00); idle(8);
    common_pulse();
    finish_event("R5 limit");
    cfg_fullscale = 12'hFFF;
  endtask

  task automatic t_sparse();
    // ch4 values 21,20,5,4 with constant 20: only 21 survives
    cfg_edge = 2'b11;
    cfg_sparse[4*16 +: 16] = 16'd20;
    begin_event();
    drive(8'h10); drive(8'h00); idle(14);
    drive(8'h10); drive(8'h00); idle(3);
    common_pulse();
    finish_event("R6 sparse");
    cfg_sparse = '0;
    cfg_edge = 2'b01;
  endtask

  task automatic t_start_mode();
    cfg_stop_mode = 1'b0;
    begin_event();
    pulse(1); idle(2);
    common_pulse();
    idle(3); pulse(1); idle(2); pulse(6); pulse(1); idle(2);
    timeout_pulse();
    finish_event("R9 R4 start");
    cfg_stop_mode = 1'b1;
    m_rec = 1'b1;
  endtask

  task automatic t_backpressure();
    bp_mode = 1'b1;
    begin_event();
    for (int i = 0; i < 4; i++) begin pulse(0); pulse(3); pulse(7); end
    idle(1);
    common_pulse();
    pulse(6); pulse(6);
    finish_event("R10 backpressure");
    begin_event();
    idle(2);
    common_pulse();
    finish_event("R10 empty after");
    bp_mode = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    clear_model();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    t_reset();
    t_basic_stop();
    t_edges();
    t_depth();
    t_fullscale();
    t_sparse();
    t_start_mode();
    t_backpressure();
    summary();
  end

endmodule